// File: doc/BRIEF.md
# Bi-quinary decade counter

This block is a four-bit counter made of two separate stages: a toggle stage on bit 0 that divides by two, and a three-bit stage on bits 3..1 that counts 0 to 4 and divides by five. A two-bit mode input chooses how the stages are linked. They can run unlinked, as one divide-by-2 and one divide-by-5 counter. They can be chained so the pair counts a decade in 8421 BCD order. They can also be chained the other way round, in bi-quinary order, where the five-stage counts fastest and bit 0 shows which half of the decade is active.

Everything runs on one system clock. The two count strobes, one for each stage, are sampled on that clock. Each cycle in which a strobe is high counts once. When the stages are chained, the driven stage moves in the same cycle as the carry that drives it, so one external strobe moves the whole decade by exactly one. Each bit has its own asynchronous set, and one asynchronous clear acts on all four bits. A one-cycle terminal-count pulse marks each wrap of the decade. Inverted copies of bit 0 and bit 3 are also provided.

Top module: `bq_decade_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 0 and `tc_o` is 0. The low level takes effect at once. After `rst_n` rises, counting resumes once the two-stage release synchronizer has filled.
- R2: `q0_n_o` always equals the inverse of `q_o[0]`, and `q3_n_o` always equals the inverse of `q_o[3]`.
- R3: Mode 2'b00 (split) runs the stages unlinked. A cycle with `cnt_a_i` high toggles `q_o[0]`. A cycle with `cnt_b_i` high advances `q_o[3:1]` in binary, with `q_o[1]` as the LSB, through 0,1,2,3,4 and back to 0. Neither stage carries into the other.
- R4: Mode 2'b01 (BCD) counts on `cnt_a_i`. Read as the 4-bit number {q3,q2,q1,q0}, `q_o` steps 0,1,...,9 and then returns to 0. `cnt_b_i` has no effect in this mode.
- R5: Mode 2'b10 (bi-quinary) counts on `cnt_b_i`, which advances `q_o[3:1]` from 0 to 4. In the same cycle that `q_o[3:1]` goes from 4 to 0, `q_o[0]` toggles. As a 4-bit number, `q_o` therefore steps 0,2,4,6,8,1,3,5,7,9,0. `cnt_a_i` has no effect in this mode.
- R6: `tc_o` is high for exactly the one cycle in which `q_o` first shows 0 after a decade wrap: 9 to 0 in BCD mode, or `q_o[3:1]` going from 4 to 0 while `q_o[0]` is 1 in bi-quinary mode. `tc_o` is never high in modes 2'b00 or 2'b11.
- R7: Mode 2'b11 holds the state. Both strobes are ignored.
- R8: `set_i[k]` high forces `q_o[k]` to 1 at once, without waiting for a clock edge. While `set_i[k]` stays high it overrides counting for that bit.
- R9: `clear_i` high forces `q_o` to 0 and `tc_o` to 0 at once. It wins over any `set_i` bit that is high at the same time.
- R10: If `q_o[3:1]` holds an unused code (5, 6 or 7), the next step of the five-stage loads 0, and no carry or terminal count is produced.
- R11: Each clock cycle with the active strobe high counts once. A strobe held high for N cycles counts N times. A chained stage moves in the same cycle as its driving stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset: asserts asynchronously, released synchronously |
| mode_i | input | 2 | Stage linking: 00 split, 01 BCD, 10 bi-quinary, 11 hold |
| cnt_a_i | input | 1 | Count strobe for the divide-by-two stage (bit 0) |
| cnt_b_i | input | 1 | Count strobe for the divide-by-five stage (bits 3..1) |
| set_i | input | 4 | Asynchronous set, one per state bit |
| clear_i | input | 1 | Asynchronous clear of all state bits and of the terminal count |
| q_o | output | 4 | Counter state bits |
| q0_n_o | output | 1 | Inverse of bit 0 |
| q3_n_o | output | 1 | Inverse of bit 3 |
| tc_o | output | 1 | One-cycle pulse on a decade wrap |

## Verification
The clocked properties assume that `set_i` and `clear_i` are pulsed between clock edges, so that an edge never samples them at the same time as a counting step. Any property whose window contains a set or clear pulse would otherwise be comparing values that were overridden asynchronously. The properties also assume the strobes and the mode stay stable around the rising edge. The stimulus changes every input just after a falling edge and releases every set and clear pulse before the next rising edge. No set or clear pulse is placed inside the window of a mode-hold or stepping property.

// File: rtl/bq_pkg.sv
package bq_pkg;

  typedef enum logic [1:0] {
    BQ_MODE_SPLIT = 2'b00,
    BQ_MODE_BCD   = 2'b01,
    BQ_MODE_BIQ   = 2'b10,
    BQ_MODE_HOLD  = 2'b11
  } bq_mode_e;

  localparam int QUIN_MOD  = 5;
  localparam int QUIN_W    = $clog2(QUIN_MOD);
  localparam int QUIN_LAST = QUIN_MOD - 1;
  localparam int STATE_W   = QUIN_W + 1;

endpackage

// File: rtl/bq_bit_ff.sv
module bq_bit_ff (
  input  logic clk,
  input  logic clr_i,
  input  logic set_i,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);

  // Clear takes priority over set; both override the clock enable.
  always_ff @(posedge clk or posedge clr_i or posedge set_i) begin
    if (clr_i) begin
      q_o <= 1'b0;
    end else if (set_i) begin
      q_o <= 1'b1;
    end else if (en_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/bq_div2_stage.sv
module bq_div2_stage (
  input  logic clk,
  input  logic clr_i,
  input  logic set_i,
  input  logic step_i,
  output logic q_o
);

  logic toggle_d;

  always_comb begin
    toggle_d = ~q_o;
  end

  bq_bit_ff u_bit (
    .clk   (clk),
    .clr_i (clr_i),
    .set_i (set_i),
    .en_i  (step_i),
    .d_i   (toggle_d),
    .q_o   (q_o)
  );

endmodule

// File: rtl/bq_div5_stage.sv
module bq_div5_stage
  import bq_pkg::*;
(
  input  logic              clk,
  input  logic              clr_i,
  input  logic [QUIN_W-1:0] set_i,
  input  logic              step_i,
  output logic [QUIN_W-1:0] q_o,
  output logic              last_o
);

  localparam logic [QUIN_W-1:0] LAST_CODE = QUIN_W'(QUIN_LAST);

  logic [QUIN_W-1:0] quin_nxt;

  // Legal codes below the last one increment; the last code and every
  // unused code load zero, so the stage cannot stay in an unused code.
  always_comb begin
    if (q_o < LAST_CODE) begin
      quin_nxt = q_o + QUIN_W'(1);
    end else begin
      quin_nxt = '0;
    end
  end

  always_comb begin
    last_o = (q_o == LAST_CODE);
  end

  for (genvar gi = 0; gi < QUIN_W; gi++) begin : g_bit
    bq_bit_ff u_bit (
      .clk   (clk),
      .clr_i (clr_i),
      .set_i (set_i[gi]),
      .en_i  (step_i),
      .d_i   (quin_nxt[gi]),
      .q_o   (q_o[gi])
    );
  end

endmodule

// File: rtl/bq_chain_ctrl.sv
module bq_chain_ctrl
  import bq_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       cnt_a_i,
  input  logic       cnt_b_i,
  input  logic       bin_q_i,
  input  logic       quin_last_i,
  output logic       step_bin_o,
  output logic       step_quin_o,
  output logic       wrap_o
);

  bq_mode_e mode;

  always_comb begin
    mode = bq_mode_e'(mode_i);
  end

  always_comb begin
    step_bin_o  = 1'b0;
    step_quin_o = 1'b0;
    wrap_o      = 1'b0;
    case (mode)
      BQ_MODE_SPLIT: begin
        step_bin_o  = cnt_a_i;
        step_quin_o = cnt_b_i;
      end
      BQ_MODE_BCD: begin
        step_bin_o  = cnt_a_i;
        step_quin_o = cnt_a_i & bin_q_i;
        wrap_o      = cnt_a_i & bin_q_i & quin_last_i;
      end
      BQ_MODE_BIQ: begin
        step_quin_o = cnt_b_i;
        step_bin_o  = cnt_b_i & quin_last_i;
        wrap_o      = cnt_b_i & quin_last_i & bin_q_i;
      end
      BQ_MODE_HOLD: begin
        step_bin_o  = 1'b0;
        step_quin_o = 1'b0;
      end
      default: begin
        step_bin_o  = 1'b0;
        step_quin_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
  import bq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               cnt_a_i,
  input  logic               cnt_b_i,
  input  logic [STATE_W-1:0] set_i,
  input  logic               clear_i,
  output logic [STATE_W-1:0] q_o,
  output logic               q0_n_o,
  output logic               q3_n_o,
  output logic               tc_o
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic                   clr_any;
  logic                   bin_q;
  logic [QUIN_W-1:0]      quin_q;
  logic                   quin_last;
  logic                   step_bin;
  logic                   step_quin;
  logic                   wrap;

  // Reset asserts at once and is released through a short synchronizer.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  always_comb begin
    rst_sync_n = rst_pipe[SYNC_STAGES-1];
    clr_any    = ~rst_sync_n | clear_i;
  end

  bq_chain_ctrl u_chain (
    .mode_i      (mode_i),
    .cnt_a_i     (cnt_a_i),
    .cnt_b_i     (cnt_b_i),
    .bin_q_i     (bin_q),
    .quin_last_i (quin_last),
    .step_bin_o  (step_bin),
    .step_quin_o (step_quin),
    .wrap_o      (wrap)
  );

  bq_div2_stage u_div2 (
    .clk    (clk),
    .clr_i  (clr_any),
    .set_i  (set_i[0]),
    .step_i (step_bin),
    .q_o    (bin_q)
  );

  bq_div5_stage u_div5 (
    .clk    (clk),
    .clr_i  (clr_any),
    .set_i  (set_i[STATE_W-1:1]),
    .step_i (step_quin),
    .q_o    (quin_q),
    .last_o (quin_last)
  );

  bq_bit_ff u_tc (
    .clk   (clk),
    .clr_i (clr_any),
    .set_i (1'b0),
    .en_i  (1'b1),
    .d_i   (wrap),
    .q_o   (tc_o)
  );

  always_comb begin
    q_o    = {quin_q, bin_q};
    q0_n_o = ~bin_q;
    q3_n_o = ~quin_q[QUIN_W-1];
  end

endmodule

// File: rtl/bq_decade_counter_chk.sv
module bq_decade_counter_chk (
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] mode_i,
  input logic       cnt_a_i,
  input logic       cnt_b_i,
  input logic [3:0] set_i,
  input logic       clear_i,
  input logic [3:0] q_o,
  input logic       tc_o
);

  AST_BCD_STEP: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    (mode_i == 2'b01 && cnt_a_i && q_o < 4'd9) |=> (q_o == $past(q_o) + 4'd1)); // R4

  AST_BCD_WRAP: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    (mode_i == 2'b01 && cnt_a_i && q_o == 4'd9) |=> (q_o == 4'd0 && tc_o)); // R6

  AST_BIQ_CARRY: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    (mode_i == 2'b10 && cnt_b_i && q_o[3:1] == 3'd4) |=> (q_o[3:1] == 3'd0 && q_o[0] != $past(q_o[0]))); // R5

  AST_HOLD_MODE: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    (mode_i == 2'b11) |=> $stable(q_o)); // R7

  AST_NO_LOCKUP: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    (mode_i == 2'b00 && cnt_b_i && q_o[3:1] > 3'd4) |=> (q_o[3:1] == 3'd0)); // R10

  AST_TC_SINGLE: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    tc_o |=> !tc_o); // R6

  AST_TC_AT_ZERO: assert property (@(posedge clk)
    disable iff (!rst_sync_n || clear_i || (|set_i))
    tc_o |-> (q_o == 4'd0)); // R6

  AST_CLEAR_WINS: assert property (@(posedge clk)
    disable iff (!rst_sync_n)
    clear_i |-> (q_o == 4'd0 && !tc_o)); // R9

endmodule

bind bq_decade_counter bq_decade_counter_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .mode_i     (mode_i),
  .cnt_a_i    (cnt_a_i),
  .cnt_b_i    (cnt_b_i),
  .set_i      (set_i),
  .clear_i    (clear_i),
  .q_o        (q_o),
  .tc_o       (tc_o)
);

// File: tb/bq_decade_counter_test.sv
module bq_decade_counter_test;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode_i;
  logic       cnt_a_i;
  logic       cnt_b_i;
  logic [3:0] set_i;
  logic       clear_i;
  logic [3:0] q_o;
  logic       q0_n_o;
  logic       q3_n_o;
  logic       tc_o;

  int checks = 0;
  int errors = 0;

  bq_decade_counter uut (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .cnt_a_i (cnt_a_i),
    .cnt_b_i (cnt_b_i),
    .set_i   (set_i),
    .clear_i (clear_i),
    .q_o     (q_o),
    .q0_n_o  (q0_n_o),
    .q3_n_o  (q3_n_o),
    .tc_o    (tc_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mode[8:7], cnt_a[6], cnt_b[5], expected q[4:1], expected tc[0]}
  localparam int NVEC = 30;
  localparam logic [8:0] VEC [NVEC] = '{
    {2'b01, 1'b1, 1'b0, 4'd1, 1'b0},  // R4 BCD counting
    {2'b01, 1'b1, 1'b0, 4'd2, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd3, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd4, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd5, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd6, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd7, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd8, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd9, 1'b0},
    {2'b01, 1'b1, 1'b0, 4'd0, 1'b1},  // R6 BCD wrap
    {2'b01, 1'b0, 1'b1, 4'd0, 1'b0},  // R4 cnt_b ignored
    {2'b10, 1'b0, 1'b1, 4'd2, 1'b0},  // R5 bi-quinary order
    {2'b10, 1'b0, 1'b1, 4'd4, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd6, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd8, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd1, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd3, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd5, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd7, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd9, 1'b0},
    {2'b10, 1'b0, 1'b1, 4'd0, 1'b1},  // R6 bi-quinary wrap
    {2'b10, 1'b1, 1'b0, 4'd0, 1'b0},  // R5 cnt_a ignored
    {2'b00, 1'b1, 1'b0, 4'd1, 1'b0},  // R3 split mode
    {2'b00, 1'b0, 1'b1, 4'd3, 1'b0},
    {2'b00, 1'b0, 1'b1, 4'd5, 1'b0},
    {2'b00, 1'b1, 1'b1, 4'd6, 1'b0},
    {2'b00, 1'b0, 1'b1, 4'd8, 1'b0},
    {2'b00, 1'b0, 1'b1, 4'd0, 1'b0},  // R3 no carry, R6 no tc
    {2'b00, 1'b1, 1'b0, 4'd1, 1'b0},
    {2'b11, 1'b1, 1'b1, 4'd1, 1'b0}   // R7 hold
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive after a falling edge, count on one rising edge, observe at the next falling edge.
  task automatic step(input logic [1:0] m, input logic a, input logic b);
    @(negedge clk);
    mode_i  = m;
    cnt_a_i = a;
    cnt_b_i = b;
    @(posedge clk);
    #1;
    cnt_a_i = 1'b0;
    cnt_b_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_set(input logic [3:0] bits);
    @(negedge clk);
    #1 set_i = bits;
    #1 set_i = 4'b0000;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    mode_i  = 2'b00;
    cnt_a_i = 1'b0;
    cnt_b_i = 1'b0;
    set_i   = 4'b0000;
    clear_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {3'b0, tc_o, q_o}, 8'h00);
    check("R2", {6'b0, q0_n_o, q3_n_o}, 8'h03);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", {3'b0, tc_o, q_o}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      step(VEC[i][8:7], VEC[i][6], VEC[i][5]);
      case (VEC[i][8:7])
        2'b00:   tag = "R3";
        2'b01:   tag = "R4";
        2'b10:   tag = "R5";
        default: tag = "R7";
      endcase
      check(tag, {4'b0, q_o}, {4'b0, VEC[i][4:1]});
      check("R6", {7'b0, tc_o}, {7'b0, VEC[i][0]});
    end

    // Leave the hold mode before any asynchronous pulses.
    step(2'b00, 1'b0, 1'b0);
    check("R3", {4'b0, q_o}, 8'h01);

    // R8: the set acts with no clock edge; R2 complement follows.
    @(negedge clk);
    #1 set_i = 4'b1000;
    #1;
    check("R8", {4'b0, q_o}, 8'h09);
    check("R2", {6'b0, q0_n_o, q3_n_o}, {6'b0, ~q_o[0], 1'b0});
    set_i = 4'b0000;

    // R8: a held set overrides the toggle of bit 0.
    @(negedge clk);
    set_i   = 4'b0001;
    cnt_a_i = 1'b1;
    @(posedge clk);
    #1 cnt_a_i = 1'b0;
    @(negedge clk);
    check("R8", {4'b0, q_o}, 8'h09);
    set_i = 4'b0000;

    // R9: the clear wins over all sets.
    @(negedge clk);
    #1 begin set_i = 4'b1111; clear_i = 1'b1; end
    #1;
    check("R9", {3'b0, tc_o, q_o}, 8'h00);
    set_i = 4'b0000;
    #1 clear_i = 1'b0;
    #1 check("R9", {4'b0, q_o}, 8'h00);

    // R10: an unused code recovers in split mode.
    pulse_set(4'b1110);
    check("R8", {4'b0, q_o}, 8'h0e);
    step(2'b00, 1'b0, 1'b1);
    check("R10", {4'b0, q_o}, 8'h00);

    // R10: from 15 in BCD mode the decade gives 0 without a terminal count.
    pulse_set(4'b1111);
    step(2'b01, 1'b1, 1'b0);
    check("R10", {3'b0, tc_o, q_o}, 8'h00);

    // R10: from an unused code in bi-quinary mode bit 0 does not toggle.
    pulse_set(4'b1010);
    step(2'b10, 1'b0, 1'b1);
    check("R10", {3'b0, tc_o, q_o}, 8'h00);

    // R11: a strobe held high for three cycles counts three times.
    @(negedge clk);
    mode_i  = 2'b01;
    cnt_a_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 cnt_a_i = 1'b0;
    @(negedge clk);
    check("R11", {4'b0, q_o}, 8'h03);

    // R1: the reset acts at once during operation.
    @(negedge clk);
    #1 rst_n = 1'b0;
    #1 check("R1", {3'b0, tc_o, q_o}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(2'b01, 1'b1, 1'b0);
    check("R1", {4'b0, q_o}, 8'h01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule